// File: doc/BRIEF.md
# Boost Converter Startup and Fault Sequencer

This block is the digital control state machine of a step-up converter. It brings the converter out of shutdown in stages. First it precharges the output through a linear current source, trying a low current level and then a high one. Next it switches with a soft-start peak-current limit that ramps up, and finally it settles into normal boost switching. It watches a few comparator flags and sends the converter into a timed fault wait when a stage fails to complete, when the current limit is held too long, or when the output collapses. After the wait it retries automatically.

All stage timing counts a slow tick-enable input that an external fault clock produces. The outputs are:
- a state code
- a select for the precharge source current
- a 5-bit peak-current-limit code
- switching and synchronous-rectifier enables
- a load-isolation flag

A thermal flag parks the block in a separate off state until the flag clears.

Top module: `boost_seq`

## Requirements
- R1: After reset, and on the clock edge after `en` is sampled low, `state` is 0 (off). In that state `disc` is 1 and `sw_en`, `sr_en`, `lin_sel` and `ilim_code` are all 0. The state codes are: 0 off, 1 precharge-low, 2 precharge-high, 3 soft-start, 4 boost, 5 fault, 6 thermal.
- R2: From off, with `en` high, `uvlo_ok` high and `tsd` low, the next edge enters state 1 with `lin_sel` = 1 and `disc` = 0. While `uvlo_ok` is low the block stays off.
- R3: In state 1, a tick with `near_vin` high moves the block to state 3. Otherwise state 1 lasts exactly 16 ticks and then becomes state 2, with `lin_sel` = 2.
- R4: In state 2, a tick with `near_vin` high moves the block to state 3. Otherwise state 2 lasts exactly 64 ticks and then becomes state 5.
- R5: In state 3, `sw_en` is 1 and `ilim_code` starts at 8. The code rises by one every 4 ticks and reaches 16 after 32 ticks.
- R6: In state 3, a tick with `pg90` high enters state 4, where `ilim_code` is 16. With no such tick, the block goes to state 5 after 96 further ticks at code 16 (128 ticks in state 3).
- R7: In state 4, `ilim_hit` high on 32 consecutive ticks enters state 5. A tick with `ilim_hit` low restarts that count.
- R8: In state 4, `near_vin` going low drops `sr_en` in the same cycle and enters state 5 on the next edge, whether or not a tick is present.
- R9: In state 5, `sw_en` and `sr_en` are 0 and `disc` is 1. After exactly 480 ticks the block re-enters state 1.
- R10: With `en` high, `tsd` high enters state 6 (all drives off, `disc` = 1) on the next edge. Once `tsd` is low, the next edge enters state 1.
- R11: Stage timeouts and the transitions between the precharge, soft-start and fault stages happen only on edges where `tick` is high. With `tick` low, those states hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Fault-clock tick enable, one clock wide |
| en | input | 1 | Converter enable |
| uvlo_ok | input | 1 | Input supply above the undervoltage lockout threshold |
| tsd | input | 1 | Thermal shutdown flag, with hysteresis applied outside the block |
| near_vin | input | 1 | Output is above input minus 1 V |
| pg90 | input | 1 | Output is above 90% of its set point |
| ilim_hit | input | 1 | Peak current limit reached this cycle |
| state | output | 3 | State code (see R1) |
| lin_sel | output | 2 | Precharge source: 0 off, 1 low level, 2 high level |
| ilim_code | output | 5 | Peak current limit code, where 16 is full scale |
| sw_en | output | 1 | Boost switching enable |
| sr_en | output | 1 | Synchronous rectifier enable |
| disc | output | 1 | Load isolated from input in both directions |

## Verification
The hardest situation to reach is the tail of each long timeout. The bench has to sit exactly one tick short of the 128-tick soft-start limit, the 480-tick retry and the 32-tick current-limit run, and then see the state change on precisely the next tick. To get there, the stimulus holds the comparator flags steady for counted runs of edges. It also breaks the current-limit run with a single low tick so that the restarted count is what gets measured. A long stretch with the tick held low in the fault state shows that only ticks advance the timers. A collapse injected with the tick held low shows that the collapse fault does not wait for a tick.

// File: rtl/boost_seq_pkg.sv
package boost_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_LINLO = 3'd1,
    ST_LINHI = 3'd2,
    ST_SOFT  = 3'd3,
    ST_BOOST = 3'd4,
    ST_FAULT = 3'd5,
    ST_HOT   = 3'd6
  } seq_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/boost_seq_timer.sv
module boost_seq_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (clr)      cnt_nxt = '0;
    else if (inc) cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

endmodule

// File: rtl/boost_seq_ramp.sv
module boost_seq_ramp #(
  parameter int CNT_W  = 9,
  parameter int CODE_W = 5,
  parameter int START  = 8,
  parameter int FULL   = 16,
  parameter int STEP   = 4
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic              in_soft,
  input  logic              in_boost,
  output logic [CODE_W-1:0] code
);

  localparam int SPAN = FULL - START;

  logic [CNT_W-1:0] steps;

  generate
    if ((STEP & (STEP - 1)) == 0) begin : g_shift
      assign steps = cnt >> $clog2(STEP);
    end else begin : g_div
      assign steps = cnt / CNT_W'(STEP);
    end
  endgenerate

  always_comb begin
    code = '0;
    if (in_boost) begin
      code = CODE_W'(FULL);
    end else if (in_soft) begin
      if (steps >= CNT_W'(SPAN)) code = CODE_W'(FULL);
      else                       code = CODE_W'(START) + steps[CODE_W-1:0];
    end
  end

endmodule

// File: rtl/boost_seq.sv
module boost_seq
  import boost_seq_pkg::*;
#(
  parameter int LIN1_TICKS  = 16,
  parameter int LIN2_TICKS  = 64,
  parameter int RAMP_STEP   = 4,
  parameter int CODE_START  = 8,
  parameter int CODE_FULL   = 16,
  parameter int SS_HOLD     = 96,
  parameter int ILIM_TICKS  = 32,
  parameter int RETRY_TICKS = 480
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       uvlo_ok,
  input  logic       tsd,
  input  logic       near_vin,
  input  logic       pg90,
  input  logic       ilim_hit,
  output logic [2:0] state,
  output logic [1:0] lin_sel,
  output logic [4:0] ilim_code,
  output logic       sw_en,
  output logic       sr_en,
  output logic       disc
);

  localparam int RAMP_TICKS = (CODE_FULL - CODE_START) * RAMP_STEP;
  localparam int SS_TICKS   = RAMP_TICKS + SS_HOLD;
  localparam int MAX_TICKS  = max2(max2(LIN1_TICKS, LIN2_TICKS),
                                   max2(max2(SS_TICKS, ILIM_TICKS), RETRY_TICKS));
  localparam int CNT_W      = $clog2(MAX_TICKS + 1);
  localparam int CODE_W     = 5;

  seq_state_t       st, st_nxt;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cnt_inc;
  logic             timed;

  // next-state process
  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_OFF:   if (uvlo_ok) st_nxt = ST_LINLO;
      ST_LINLO: if (tick) begin
                  if (near_vin)                            st_nxt = ST_SOFT;
                  else if (cnt == CNT_W'(LIN1_TICKS - 1))  st_nxt = ST_LINHI;
                end
      ST_LINHI: if (tick) begin
                  if (near_vin)                            st_nxt = ST_SOFT;
                  else if (cnt == CNT_W'(LIN2_TICKS - 1))  st_nxt = ST_FAULT;
                end
      ST_SOFT:  if (tick) begin
                  if (pg90)                                st_nxt = ST_BOOST;
                  else if (cnt == CNT_W'(SS_TICKS - 1))    st_nxt = ST_FAULT;
                end
      ST_BOOST: if (!near_vin) st_nxt = ST_FAULT;
                else if (tick && ilim_hit && cnt == CNT_W'(ILIM_TICKS - 1))
                  st_nxt = ST_FAULT;
      ST_FAULT: if (tick && cnt == CNT_W'(RETRY_TICKS - 1)) st_nxt = ST_LINLO;
      ST_HOT:   st_nxt = ST_LINLO;
      default:  st_nxt = ST_OFF;
    endcase
    if (tsd) st_nxt = ST_HOT;
    if (!en) st_nxt = ST_OFF;
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OFF;
    else        st <= st_nxt;
  end

  // stage counter control: clears on every state change, and in boost on any tick without current limit
  assign timed   = (st == ST_LINLO) || (st == ST_LINHI) || (st == ST_SOFT) ||
                   (st == ST_BOOST) || (st == ST_FAULT);
  assign cnt_inc = tick && timed;
  assign cnt_clr = (st_nxt != st) || ((st == ST_BOOST) && tick && !ilim_hit);

  boost_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (cnt)
  );

  boost_seq_ramp #(
    .CNT_W  (CNT_W),
    .CODE_W (CODE_W),
    .START  (CODE_START),
    .FULL   (CODE_FULL),
    .STEP   (RAMP_STEP)
  ) u_ramp (
    .cnt      (cnt),
    .in_soft  (st == ST_SOFT),
    .in_boost (st == ST_BOOST),
    .code     (ilim_code)
  );

  // output decode
  always_comb begin
    state   = st;
    lin_sel = 2'd0;
    if (st == ST_LINLO) lin_sel = 2'd1;
    if (st == ST_LINHI) lin_sel = 2'd2;
    sw_en   = (st == ST_SOFT) || (st == ST_BOOST);
    sr_en   = sw_en && near_vin;
    disc    = (st == ST_OFF) || (st == ST_FAULT) || (st == ST_HOT);
  end

endmodule

// File: rtl/boost_seq_chk.sv
module boost_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       en,
  input logic       tsd,
  input logic       near_vin,
  input logic [2:0] state,
  input logic [4:0] ilim_code,
  input logic       sw_en,
  input logic       disc
);

  // R1
  en_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state == 3'd0);

  // R5
  ramp_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd3 && $past(state) == 3'd3) |->
      (ilim_code == $past(ilim_code) || ilim_code == $past(ilim_code) + 5'd1));

  // R5
  code_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_code <= 5'd16);

  // R8
  collapse_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && !near_vin && en && !tsd) |=> state == 3'd5);

  // R9
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd5) |-> (disc && !sw_en));

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && en && !tsd && (state == 3'd1 || state == 3'd2 ||
                             state == 3'd3 || state == 3'd5)) |=> $stable(state));

endmodule

bind boost_seq boost_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .en        (en),
  .tsd       (tsd),
  .near_vin  (near_vin),
  .state     (state),
  .ilim_code (ilim_code),
  .sw_en     (sw_en),
  .disc      (disc)
);

// File: tb/boost_seq_test.sv
module boost_seq_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    string    req;
    bit [2:0] st;
    bit [1:0] lin;
    bit [4:0] code;
    bit       sw;
    bit       sr;
    bit       disc;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, tick, en, uvlo_ok, tsd, near_vin, pg90, ilim_hit;
  logic [2:0] state;
  logic [1:0] lin_sel;
  logic [4:0] ilim_code;
  logic sw_en, sr_en, disc;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  exp_t q[$];
  event item_ev;

  always #(CLK_PERIOD / 2) clk = ~clk;

  boost_seq uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .uvlo_ok(uvlo_ok),
    .tsd(tsd), .near_vin(near_vin), .pg90(pg90), .ilim_hit(ilim_hit),
    .state(state), .lin_sel(lin_sel), .ilim_code(ilim_code),
    .sw_en(sw_en), .sr_en(sr_en), .disc(disc)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side: derive every output the requirements fix for the given state
  task automatic expect_st(input string req, input int s, input int soft_code);
    exp_t e;
    e.req  = req;
    e.st   = 3'(s);
    e.lin  = (s == 1) ? 2'd1 : (s == 2) ? 2'd2 : 2'd0;
    e.code = (s == 4) ? 5'd16 : (s == 3) ? 5'(soft_code) : 5'd0;
    e.sw   = (s == 3 || s == 4);
    e.sr   = e.sw && near_vin;
    e.disc = (s == 0 || s == 5 || s == 6);
    q.push_back(e);
    -> item_ev;
    #2;
  endtask

  // monitor side: pops and compares
  initial begin
    forever begin
      @(item_ev);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        compared++;
        if (state !== e.st || lin_sel !== e.lin || ilim_code !== e.code ||
            sw_en !== e.sw || sr_en !== e.sr || disc !== e.disc) begin
          mismatched++;
          $display("FAIL %s: got st=%0d lin=%0d code=%0d sw=%0b sr=%0b disc=%0b, expected st=%0d lin=%0d code=%0d sw=%0b sr=%0b disc=%0b",
                   e.req, state, lin_sel, ilim_code, sw_en, sr_en, disc,
                   e.st, e.lin, e.code, e.sw, e.sr, e.disc);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick = 1; en = 0; uvlo_ok = 1; tsd = 0;
    near_vin = 0; pg90 = 0; ilim_hit = 0;
    cyc(3);
    expect_st("R1", 0, 0);
    rst_n = 1;
    cyc(2);  expect_st("R1", 0, 0);

    en = 1;
    cyc(1);  expect_st("R2", 1, 0);
    cyc(15); expect_st("R3", 1, 0);
    cyc(1);  expect_st("R3", 2, 0);
    cyc(63); expect_st("R4", 2, 0);
    cyc(1);  expect_st("R4", 5, 0);
    cyc(479); expect_st("R9", 5, 0);
    cyc(1);  expect_st("R9", 1, 0);

    cyc(3);  near_vin = 1;
    cyc(1);  expect_st("R3", 3, 8);
    cyc(4);  expect_st("R5", 3, 9);
    cyc(27); expect_st("R5", 3, 15);
    cyc(1);  expect_st("R5", 3, 16);
    cyc(95); expect_st("R6", 3, 16);
    cyc(1);  expect_st("R6", 5, 0);

    cyc(480); expect_st("R9", 1, 0);
    cyc(1);  expect_st("R3", 3, 8);
    cyc(10); expect_st("R5", 3, 10);
    pg90 = 1;
    cyc(1);  expect_st("R6", 4, 16);

    ilim_hit = 1;
    cyc(20); expect_st("R7", 4, 0);
    ilim_hit = 0;
    cyc(1);  expect_st("R7", 4, 0);
    ilim_hit = 1;
    cyc(31); expect_st("R7", 4, 0);
    cyc(1);  expect_st("R7", 5, 0);
    ilim_hit = 0;

    tick = 0;
    cyc(600); expect_st("R11", 5, 0);
    tick = 1;
    cyc(479); expect_st("R11", 5, 0);
    cyc(1);  expect_st("R9", 1, 0);
    cyc(1);  expect_st("R3", 3, 8);
    cyc(1);  expect_st("R6", 4, 16);

    tick = 0;
    near_vin = 0;
    #1;
    expect_st("R8", 4, 0);
    cyc(1);  expect_st("R8", 5, 0);
    tick = 1;

    en = 0;
    cyc(1);  expect_st("R1", 0, 0);

    en = 1;
    cyc(1);  expect_st("R2", 1, 0);
    tsd = 1;
    cyc(1);  expect_st("R10", 6, 0);
    cyc(5);  expect_st("R10", 6, 0);
    tsd = 0;
    cyc(1);  expect_st("R10", 1, 0);

    en = 0;
    cyc(1);  expect_st("R1", 0, 0);
    uvlo_ok = 0; en = 1;
    cyc(3);  expect_st("R2", 0, 0);
    uvlo_ok = 1;
    cyc(1);  expect_st("R2", 1, 0);
    cyc(16); expect_st("R3", 2, 0);
    cyc(5);  near_vin = 1;
    cyc(1);  expect_st("R4", 3, 8);

    cyc(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule